// File: doc/BRIEF.md
# SPI Serial Clock and Edge Strobe Generator

This block derives the SPI serial clock from a faster reference clock. It does not divide by an integer. On each reference cycle it adds a frequency word to an 11-bit phase accumulator that wraps at 2048. The top bit of the accumulator is the clock phase. This gives an average SCLK rate equal to the reference rate times the word divided by 2048, so rates that are not integer fractions of the reference can be produced.

Alongside the clock, the block issues two single-cycle enables to the shifting logic of the transfer engine:

- a launch enable, which marks when new transmit data should be driven;
- a latch enable, which marks when receive data should be captured.

Each enable is tied to the rising or the falling pin edge of SCLK by its own select bit. A polarity bit sets the idle level of SCLK. A gate bit and a run request together decide whether the clock runs at all. An optional restart flag clears the accumulator between transfers, so the first edge of every transfer comes at the same delay.

Top module: `spi_sclk_gen`

## Requirements
- R1: With a frequency word F between 1 and 1023 and the clock running, the phase accumulator advances by F per reference cycle modulo 2048. SCLK equals the polarity bit XOR accumulator bit 10. Over a window starting from phase 0, SCLK therefore toggles once for every 1024 of accumulated increment.
- R2: A frequency word of 0 keeps SCLK at its idle level and produces no launch or latch enable, even when run and gate are high.
- R3: A frequency word of 1024 or more acts as 1024. SCLK then changes level on every reference cycle while running, which is half the reference rate.
- R4: While the run request or the gate bit is low, no enable is produced, and SCLK is at its idle level from the first reference edge onward.
- R5: launchEn is high for exactly the cycle in which SCLK has just taken a new level. With the launch select set to 1 it fires on rising pin edges (SCLK now 1). With it set to 0 it fires on falling pin edges (SCLK now 0).
- R6: latchEn follows the same timing, with the latch select bit choosing rising (1) or falling (0) pin edges. This choice is independent of the launch select.
- R7: With the restart flag set, an idle cycle clears the whole accumulator, so the first SCLK edge after run rises comes after ceil(1024/F) reference edges. With the flag clear, an idle cycle keeps the accumulator's low 10 bits, and the first edge comes after ceil((1024 - kept)/F) edges.
- R8: An idle cycle clears accumulator bit 10. The first SCLK change after idle is therefore always a move away from the idle level.
- R9: During reset, the accumulator is 0, SCLK equals the polarity bit, and both enables are low.
- R10: The polarity bit sets the idle level of SCLK (0 or 1). The edge selects always refer to the pin level, not to the internal phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| gateEn | input | 1 | Global clock enable |
| runReq | input | 1 | Transfer in progress; clock runs while high |
| freqWord | input | 14 | Phase increment per reference cycle |
| restartEn | input | 1 | Clear the accumulator on idle cycles |
| launchRise | input | 1 | 1: launch on rising pin edge, 0: on falling |
| latchRise | input | 1 | 1: latch on rising pin edge, 0: on falling |
| clkPol | input | 1 | Idle level of SCLK |
| sclk | output | 1 | Serial clock |
| launchEn | output | 1 | One-cycle transmit launch enable |
| latchEn | output | 1 | One-cycle receive latch enable |

## Verification
A behavioural model runs beside the block and is compared on every cycle, under four kinds of input:

- **Slow binary word (256).** Its exact toggle count separates a correct modulo-2048 wrap from an off-by-one divider.
- **Oversized word.** It shows whether clamping happens, rather than the word being truncated to its low bits.
- **Zero word and dropped gate.** These tell a true idle from a clock that merely stalls.
- **Odd word (300) with the restart flag set and then cleared.** The first-edge delay differs (four edges against three), which separates full clearing from keeping the fraction.

A pass with inverted polarity and swapped edge selects, then a long random run, checks that the strobe direction follows the pin level.

// File: rtl/spi_sclk_gen_pkg.sv
package spi_sclk_gen_pkg;

  // Strobes from the control to the datapath for one reference cycle.
  typedef struct packed {
    logic advance;   // add the step to the accumulator
    logic clearAll;  // idle cycle: clear every accumulator bit
  } sclkCtl_t;

endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import spi_sclk_gen_pkg::*;
#(
  parameter int FREQ_W = 14,
  parameter int ACC_W  = 11
) (
  input  logic              gateEn,
  input  logic              runReq,
  input  logic              restartEn,
  input  logic [FREQ_W-1:0] freqWord,
  output sclkCtl_t          ctl,
  output logic [ACC_W-1:0]  step
);
  localparam int MAX_STEP = 1 << (ACC_W - 1);
  localparam logic [FREQ_W-1:0] STEP_LIMIT = FREQ_W'(MAX_STEP);

  logic running;

  always_comb begin
    running = gateEn && runReq && (freqWord != '0);
    if (freqWord >= STEP_LIMIT) step = ACC_W'(MAX_STEP);
    else                        step = freqWord[ACC_W-1:0];
    ctl.advance  = running;
    ctl.clearAll = !running && restartEn;
  end
endmodule

// File: rtl/sclk_dp.sv
module sclk_dp
  import spi_sclk_gen_pkg::*;
#(
  parameter int ACC_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  sclkCtl_t         ctl,
  input  logic [ACC_W-1:0] step,
  input  logic             launchRise,
  input  logic             latchRise,
  input  logic             clkPol,
  output logic             sclk,
  output logic             launchEn,
  output logic             latchEn
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] acc, accNext;
  logic phaseFlip, pinNew;

  always_comb begin
    if (ctl.advance)       accNext = acc + step;
    else if (ctl.clearAll) accNext = '0;
    else                   accNext = {1'b0, acc[MSB-1:0]};
    phaseFlip = ctl.advance && (accNext[MSB] != acc[MSB]);
    pinNew    = clkPol ^ accNext[MSB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      launchEn <= 1'b0;
      latchEn  <= 1'b0;
    end else begin
      acc      <= accNext;
      launchEn <= phaseFlip && (pinNew == launchRise);
      latchEn  <= phaseFlip && (pinNew == latchRise);
    end
  end

  assign sclk = clkPol ^ acc[MSB];
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_gen_pkg::*;
#(
  parameter int FREQ_W = 14,
  parameter int ACC_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gateEn,
  input  logic              runReq,
  input  logic [FREQ_W-1:0] freqWord,
  input  logic              restartEn,
  input  logic              launchRise,
  input  logic              latchRise,
  input  logic              clkPol,
  output logic              sclk,
  output logic              launchEn,
  output logic              latchEn
);
  sclkCtl_t         ctl;
  logic [ACC_W-1:0] step;

  sclk_ctrl #(.FREQ_W(FREQ_W), .ACC_W(ACC_W)) uCtrl (
    .gateEn(gateEn), .runReq(runReq), .restartEn(restartEn),
    .freqWord(freqWord), .ctl(ctl), .step(step)
  );

  sclk_dp #(.ACC_W(ACC_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .step(step),
    .launchRise(launchRise), .latchRise(latchRise), .clkPol(clkPol),
    .sclk(sclk), .launchEn(launchEn), .latchEn(latchEn)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int FREQ_W = 14,
  parameter int ACC_W  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              gateEn,
  input logic              runReq,
  input logic [FREQ_W-1:0] freqWord,
  input logic              launchRise,
  input logic              latchRise,
  input logic              clkPol,
  input logic              sclk,
  input logic              launchEn,
  input logic              latchEn
);
  localparam logic [FREQ_W-1:0] STEP_LIMIT = FREQ_W'(1 << (ACC_W - 1));

  logic stopped, fastRun;
  assign stopped = !gateEn || !runReq;
  assign fastRun = gateEn && runReq && (freqWord >= STEP_LIMIT);

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> (!launchEn && !latchEn)); // R4

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> (sclk == clkPol)); // R4

  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (freqWord == '0) |=> (!launchEn && !latchEn && sclk == clkPol)); // R2

  AST_FAST_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    fastRun |=> ((sclk ^ clkPol) != $past(sclk ^ clkPol))); // R3

  AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (launchEn && $stable(clkPol) && $stable(launchRise))
      |-> (sclk != $past(sclk) && sclk == launchRise)); // R5

  AST_LATCH_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (latchEn && $stable(clkPol) && $stable(latchRise))
      |-> (sclk != $past(sclk) && sclk == latchRise)); // R6

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!launchEn && !latchEn); // R9
    end
  end
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.FREQ_W(FREQ_W), .ACC_W(ACC_W)) uChk (
  .clk(clk), .rstN(rstN), .gateEn(gateEn), .runReq(runReq),
  .freqWord(freqWord), .launchRise(launchRise), .latchRise(latchRise),
  .clkPol(clkPol), .sclk(sclk), .launchEn(launchEn), .latchEn(latchEn)
);

// File: tb/sim_spi_sclk_gen.sv
`timescale 1ns/1ps
module sim_spi_sclk_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateEn = 1'b0, runReq = 1'b0, restartEn = 1'b0;
  logic launchRise = 1'b0, latchRise = 1'b0, clkPol = 1'b0;
  logic [13:0] freqWord = '0;
  logic sclk, launchEn, latchEn;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_sclk_gen u0 (
    .clk(clk), .rstN(rstN), .gateEn(gateEn), .runReq(runReq),
    .freqWord(freqWord), .restartEn(restartEn), .launchRise(launchRise),
    .latchRise(latchRise), .clkPol(clkPol), .sclk(sclk),
    .launchEn(launchEn), .latchEn(latchEn)
  );

  // Behavioural reference: phase as an integer 0..2047.
  int  mPhase = 0;
  bit  mLaunch = 0, mLatch = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mLaunch = 0; mLatch = 0;
    end else begin
      int inc, nxt;
      bit newHigh, pin;
      inc = (freqWord >= 1024) ? 1024 : int'(freqWord);
      if (gateEn && runReq && inc != 0) begin
        nxt = (mPhase + inc) % 2048;
        newHigh = (nxt >= 1024);
        pin = clkPol ^ newHigh;
        mLaunch = (newHigh != (mPhase >= 1024)) && (pin == launchRise);
        mLatch  = (newHigh != (mPhase >= 1024)) && (pin == latchRise);
        mPhase = nxt;
      end else begin
        mPhase = restartEn ? 0 : (mPhase % 1024);
        mLaunch = 0; mLatch = 0;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  int toggles = 0, launches = 0;
  logic prevSclk = 1'b0;

  // Advance n cycles, comparing against the model at each falling edge.
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1 sclk vs model", sclk, clkPol ^ (mPhase >= 1024));
      chk("R5 launchEn vs model", launchEn, mLaunch);
      chk("R6 latchEn vs model", latchEn, mLatch);
      if (sclk !== prevSclk) toggles++;
      if (launchEn) launches++;
      prevSclk = sclk;
    end
  endtask

  task automatic countFrom(input int n);
    prevSclk = sclk; toggles = 0; launches = 0;
    tick(n);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R9 reset sclk", sclk, 1'b0);
    chk("R9 reset launchEn", launchEn, 1'b0);
    rstN = 1'b1;

    // R1: word 256 from phase 0, 64 cycles -> 16 toggles
    gateEn = 1; restartEn = 1; launchRise = 1; latchRise = 0;
    freqWord = 14'd256; runReq = 1;
    countFrom(64);
    total++; if (toggles != 16) begin bad++;
      $display("FAIL R1 toggles: actual=%0d expected=16", toggles); end

    // R3: oversized word toggles every cycle
    freqWord = 14'd5000;
    countFrom(20);
    total++; if (toggles != 20) begin bad++;
      $display("FAIL R3 toggles: actual=%0d expected=20", toggles); end

    // R2: zero word keeps idle
    freqWord = 14'd0;
    tick(1);
    countFrom(20);
    total++; if (toggles != 0 || launches != 0) begin bad++;
      $display("FAIL R2 toggles: actual=%0d expected=0", toggles); end
    chk("R2 idle level", sclk, clkPol);

    // R4: gate low with a valid word
    freqWord = 14'd300; gateEn = 0;
    tick(1);
    countFrom(20);
    total++; if (toggles != 0 || launches != 0) begin bad++;
      $display("FAIL R4 toggles: actual=%0d expected=0", toggles); end
    chk("R4 idle level", sclk, clkPol);

    // R7 with restart: first edge after 4 reference edges
    gateEn = 1; runReq = 0; tick(2);
    runReq = 1;
    tick(3);
    chk("R7 restart no edge yet", sclk, clkPol);
    tick(1);
    chk("R7 restart edge at 4", sclk, ~clkPol);

    // R7 without restart: kept fraction 176 -> first edge after 3
    restartEn = 0; runReq = 0; tick(2);
    chk("R8 idle after drop", sclk, clkPol);
    runReq = 1;
    tick(2);
    chk("R7 kept fraction no edge yet", sclk, clkPol);
    tick(1);
    chk("R8 first change leaves idle", sclk, ~clkPol);

    // R10: inverted polarity, swapped edge selects
    runReq = 0; clkPol = 1; restartEn = 1; tick(2);
    chk("R10 idle high", sclk, 1'b1);
    launchRise = 0; latchRise = 1; freqWord = 14'd700; runReq = 1;
    countFrom(60);
    total++; if (launches == 0) begin bad++;
      $display("FAIL R6 launches: actual=0 expected>0"); end

    // Random run
    for (int k = 0; k < 400; k++) begin
      gateEn = ($urandom % 8) != 0;
      runReq = ($urandom % 4) != 0;
      restartEn = $urandom % 2;
      launchRise = $urandom % 2;
      latchRise = $urandom % 2;
      if (($urandom % 8) == 0) clkPol = $urandom % 2;
      case ($urandom % 4)
        0: freqWord = 14'($urandom % 1100);
        1: freqWord = 14'($urandom);
        2: freqWord = 14'd0;
        default: freqWord = 14'(1 + $urandom % 200);
      endcase
      tick(1 + $urandom % 12);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule